// File: doc/BRIEF.md
# Six-Channel Staged-Update PWM Generator

This block drives six independent pulse-width modulated outputs from one clock. Software programs each channel through a simple word-addressed register bus. The channel settings are a prescale divider, a 24-bit period count, a 24-bit active-time count and a polarity bit. These writes go into shadow storage only. A channel picks them up when its trigger bit goes from 0 to 1.

A per-channel smooth bit selects the commit mode. With smooth set, the new settings wait for the end of the running period, so the output never shows a truncated cycle. With smooth clear, the new settings load and the counters restart on the next clock. There is no enable bit. A channel is switched off by committing an active count of zero. While a channel's trigger and smooth bits are both low, its pin is held high.

Bus writes land on the rising clock edge when `wr_en` is high. Reads are combinational from `addr`.

Top module: `pwm_bank`

## Requirements
- R1: Register map, byte addressed:
  - Control word at 0x00: per channel c, trigger at bit c, polarity at bit 8+c, a stored output-type bit at 16+c, smooth at bit 24+c.
  - Prescale word at 0x04: a 3-bit field per channel at bit 4*c.
  - Period count at 0x08+8*c and active count at 0x0C+8*c, each 24 bits.
  - Every field reads back as written. Unused bits read 0.
- R2: After reset every register reads 0 and every output is high.
- R3: For committed values pre, per (at least 2) and duty, the output repeats every (pre+1)*per clocks. Counting from a commit, the first (pre+1)*duty clocks of each repetition are active. Duty 0 is never active. Duty at or above per is always active.
- R4: A committed polarity of 1 drives the pin high while active. A polarity of 0 drives it low while active.
- R5: Writes to prescale, period, active count or polarity do not change the waveform until that channel's trigger rises.
- R6: A trigger rise with smooth clear commits at once. If the write lands on edge W, the output after edge W+1 is phase 0 of the new waveform.
- R7: A trigger rise with smooth set keeps the old waveform until the first period wrap at or after edge W+2. The new waveform starts at phase 0 from that wrap. Clearing the trigger meanwhile does not cancel the pending commit.
- R8: While a channel's trigger and smooth bits are both 0, its output is constant high. Trigger 0 with smooth 1 keeps the committed waveform running.
- R9: Programming or committing one channel does not disturb the waveform of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for bus and counters |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 6 | One waveform output per channel |

## Verification
A wrong commit state shows up at the pin within one period. A pending commit that is lost or that fires early appears as a period of the wrong length, or as a change before the wrap. A prescale or period counter that is off by one shifts every later edge, so a per-clock comparison against the arithmetic waveform catches it in the first repetition. The bench sweeps prescale, period, duty and polarity across their small-value corners and compares every output clock. It also times the smooth wrap from the bench's own edge count.

// File: rtl/pwm_bank_pkg.sv
// Package: shared widths, the register offsets whose positions the bus decodes,
// and the committed per-channel configuration record.
package pwm_bank_pkg;

    localparam int unsigned PRE_W    = 3;   // prescale field width
    localparam int unsigned CNT_W    = 24;  // period / active count width
    localparam int unsigned CTRL_OFS = 0;   // control word
    localparam int unsigned PRE_OFS  = 4;   // prescale word
    localparam int unsigned CH_BASE  = 8;   // first per-channel word
    localparam int unsigned CH_STEP  = 8;   // bytes per channel pair

    // Settings for one channel, as staged or committed.
    typedef struct packed {
        logic             pol;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
    } chan_cfg_t;

    // Byte offset of the period count of a channel.
    function automatic int unsigned per_ofs(int unsigned ch);
        return CH_BASE + CH_STEP * ch;
    endfunction

    // Byte offset of the active count of a channel.
    function automatic int unsigned duty_ofs(int unsigned ch);
        return CH_BASE + CH_STEP * ch + 4;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Module: pwm_regs
// Holds the software-visible register file: the control bits, the packed
// prescale fields and the per-channel counts.
// Writes land on the clock edge when wr_en is high. Reads are combinational.
// Assumes NUM_CH <= 8, so the control bit groups fit one byte each,
// and DATA_W >= 32.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output chan_cfg_t         cfg    [NUM_CH],
    output logic [NUM_CH-1:0] trig,
    output logic [NUM_CH-1:0] smooth
);

    localparam int unsigned POL_BIT  = 8;
    localparam int unsigned TYPE_BIT = 16;
    localparam int unsigned SMTH_BIT = 24;
    localparam int unsigned PRE_STEP = 4;

    logic [NUM_CH-1:0] trig_r, pol_r, type_r, smooth_r;
    logic [PRE_W-1:0]  pre_r  [NUM_CH];
    logic [CNT_W-1:0]  per_r  [NUM_CH];
    logic [CNT_W-1:0]  duty_r [NUM_CH];

    logic sel_ctrl, sel_pre;
    assign sel_ctrl = (addr == ADDR_W'(CTRL_OFS));
    assign sel_pre  = (addr == ADDR_W'(PRE_OFS));

    // Store bus writes into the register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_r   <= '0;
            pol_r    <= '0;
            type_r   <= '0;
            smooth_r <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                pre_r[c]  <= '0;
                per_r[c]  <= '0;
                duty_r[c] <= '0;
            end
        end else if (wr_en) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (sel_ctrl) begin
                    trig_r[c]   <= wdata[c];
                    pol_r[c]    <= wdata[POL_BIT + c];
                    type_r[c]   <= wdata[TYPE_BIT + c];
                    smooth_r[c] <= wdata[SMTH_BIT + c];
                end
                if (sel_pre)
                    pre_r[c] <= wdata[PRE_STEP*c +: PRE_W];
                if (addr == ADDR_W'(per_ofs(c)))
                    per_r[c] <= wdata[CNT_W-1:0];
                if (addr == ADDR_W'(duty_ofs(c)))
                    duty_r[c] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Return the addressed word, unused bits zero.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_ctrl) begin
                rdata[c]            = trig_r[c];
                rdata[POL_BIT + c]  = pol_r[c];
                rdata[TYPE_BIT + c] = type_r[c];
                rdata[SMTH_BIT + c] = smooth_r[c];
            end
            if (sel_pre)
                rdata[PRE_STEP*c +: PRE_W] = pre_r[c];
            if (addr == ADDR_W'(per_ofs(c)))
                rdata[CNT_W-1:0] = per_r[c];
            if (addr == ADDR_W'(duty_ofs(c)))
                rdata[CNT_W-1:0] = duty_r[c];
        end
    end

    // Present the shadow settings to the channels.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            cfg[c].pol  = pol_r[c];
            cfg[c].pre  = pre_r[c];
            cfg[c].per  = per_r[c];
            cfg[c].duty = duty_r[c];
        end
    end

    assign trig   = trig_r;
    assign smooth = smooth_r;

    // R1: a write to a period or active-count word is what reads back next cycle
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        a_r1_period_store: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(per_ofs(g)))
            |=> (per_r[g] == $past(wdata[CNT_W-1:0])));
        a_r1_duty_store: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(duty_ofs(g)))
            |=> (duty_r[g] == $past(wdata[CNT_W-1:0])));
    end

endmodule

// File: rtl/pwm_chan.sv
// Module: pwm_chan
// One waveform channel. It detects the trigger rise and commits the shadow
// settings, either at once or at the next period wrap.
// It runs the prescale and period counters and forms the output.
// Assumes the shadow inputs are stable register outputs. A period count
// below 2 makes the counter wrap on every prescaled tick.
module pwm_chan
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    input  logic      trig,
    input  logic      smooth,
    output logic      pwm_out
);

    logic             trig_q;
    logic             trig_rise;
    chan_cfg_t        act;
    chan_cfg_t        stage;
    logic             pending;
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W:0]   per_nxt;
    logic             pre_tick, per_last, wrap;
    logic             load_now, load_stage;

    assign trig_rise  = trig & ~trig_q;
    assign per_nxt    = {1'b0, per_cnt} + (CNT_W+1)'(1);
    assign pre_tick   = (pre_cnt == act.pre);
    assign per_last   = (per_nxt >= {1'b0, act.per});
    assign wrap       = pre_tick & per_last;
    assign load_now   = trig_rise & ~smooth;
    assign load_stage = pending & wrap & ~load_now;

    // Remember the trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig;
    end

    // Commit settings and keep a smooth commit armed until the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= '0;
            stage   <= '0;
            pending <= 1'b0;
        end else if (load_now) begin
            act     <= cfg;
            pending <= 1'b0;
        end else begin
            if (load_stage) begin
                act     <= stage;
                pending <= 1'b0;
            end
            if (trig_rise && smooth) begin
                stage   <= cfg;
                pending <= 1'b1;
            end
        end
    end

    // Advance the prescale and period counters; restart on any commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (load_now || load_stage) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            per_cnt <= per_last ? '0 : per_nxt[CNT_W-1:0];
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    // Form the pin level from the count position and polarity.
    logic in_active;
    assign in_active = (per_cnt < act.duty);
    always_comb begin
        if (!trig && !smooth) pwm_out = 1'b1;
        else                  pwm_out = act.pol ? in_active : ~in_active;
    end

    // R6: an immediate commit restarts both counters on the next edge
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> (per_cnt == '0 && pre_cnt == '0));
    // R7: an armed smooth commit survives until a wrap or an immediate commit
    a_r7_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !wrap && !load_now) |=> pending);
    // R5: committed settings change only on a trigger rise or an armed wrap
    a_r5_no_early_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_now && !(pending && wrap)) |=> $stable(act));
    // R3: the period counter stays inside the committed period
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (act.per >= CNT_W'(2)) |-> (per_cnt < act.per));
    // R3: the prescale counter never passes the committed divider
    a_r3_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= act.pre);
    // R8: both mode bits low pins the output high
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !smooth) |-> pwm_out);

endmodule

// File: rtl/pwm_bank.sv
// Module: pwm_bank
// Top of the staged-update PWM block: one register file shared by NUM_CH
// waveform channels.
// Assumes a single clock domain and a synchronous active-low reset.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t         cfg [NUM_CH];
    logic [NUM_CH-1:0] trig, smooth;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .cfg    (cfg),
        .trig   (trig),
        .smooth (smooth)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg[g]),
            .trig    (trig[g]),
            .smooth  (smooth[g]),
            .pwm_out (pwm_out[g])
        );
    end

endmodule

// File: tb/pwm_bank_tb.sv
// Bench for pwm_bank. Sweeps small prescale/period/duty/polarity settings and
// compares every output clock against an arithmetic waveform. Commit edges
// come from the bench's own edge counter.
module pwm_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  pwm_out;

    int tests = 0, fails = 0, cyc = 0, last_edge = 0;
    bit done = 0;
    logic [31:0] ctrl_img = '0, pre_img = '0;

    pwm_bank u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

    always #4 clk = ~clk;                      // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;      // edge counter

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus write; last_edge is the edge it landed on.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; last_edge = cyc;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic set_ctrl(int ch, bit tg, bit sm, bit pol);
        ctrl_img[ch] = tg; ctrl_img[8+ch] = pol; ctrl_img[24+ch] = sm;
        wr(8'h00, ctrl_img);
    endtask

    function automatic bit exp_bit(int idx, int pre, int per, int duty, bit pol);
        int slot = idx % ((pre + 1) * per);
        bit act = (slot / (pre + 1)) < duty;
        return pol ? act : !act;
    endfunction

    // Stage settings and commit immediately; returns the commit edge.
    task automatic commit(int ch, int pre, int per, int duty, bit pol, output int c0);
        set_ctrl(ch, 0, 1, pol);
        pre_img[4*ch +: 3] = 3'(pre);
        wr(8'h04, pre_img);
        wr(8'(8 + 8*ch), 32'(per));
        wr(8'(12 + 8*ch), 32'(duty));
        set_ctrl(ch, 1, 0, pol);
        c0 = last_edge + 1;
    endtask

    // Compare n output clocks of a channel against a committed waveform.
    task automatic observe(int ch, int c0, int pre, int per, int duty, bit pol,
                           int n, string req);
        int bad = 0; bit a1 = 0, e1 = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cyc >= c0) begin
                bit e = exp_bit(cyc - c0, pre, per, duty, pol);
                if (pwm_out[ch] !== e) begin
                    if (bad == 0) begin a1 = pwm_out[ch]; e1 = e; end
                    bad++;
                end
            end
        end
        chk(bad == 0, req, 32'(a1), 32'(e1));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c0, c5, w, e, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        @(negedge clk);
        chk(pwm_out == 6'h3f, "R2 outputs", 32'(pwm_out), 32'h3f);
        for (int a = 0; a < 14; a++) begin
            rd(8'(4*a), v);
            chk(v == 0, "R2 reg zero", v, 0);
        end

        // R1: read-back and field widths
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v);
        chk(v == 32'h3F3F_3F3F, "R1 ctrl", v, 32'h3F3F_3F3F);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v);
        chk(v == 32'h0077_7777, "R1 prescale", v, 32'h0077_7777);
        wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, v);
        chk(v == 32'h00FF_FFFF, "R1 period ch5", v, 32'h00FF_FFFF);
        wr(8'h0C, 32'hA5A5_A5A5); rd(8'h0C, v);
        chk(v == 32'h00A5_A5A5, "R1 duty ch0", v, 32'h00A5_A5A5);
        rd(8'h40, v);
        chk(v == 0, "R1 unmapped", v, 0);
        ctrl_img = 0; pre_img = 0;
        wr(8'h00, 0); wr(8'h04, 0);

        // R3 R4 R6: sweep of small configurations on channel 0
        for (int pre = 0; pre < 3; pre++)
            for (int per = 2; per < 6; per++)
                for (int duty = 0; duty < 7; duty++)
                    for (int pol = 0; pol < 2; pol++) begin
                        commit(0, pre, per, duty, pol[0], c0);
                        observe(0, c0, pre, per, duty, pol[0],
                                2 * (pre + 1) * per, "R3/R4/R6 sweep");
                    end

        // R5: shadow writes without a trigger rise change nothing
        commit(0, 1, 4, 2, 1, c0);
        wr(8'h04, 0); wr(8'h08, 3); wr(8'h0C, 0);
        set_ctrl(0, 1, 0, 0);
        observe(0, c0, 1, 4, 2, 1, 24, "R5 staged only");
        // R8: trigger low with smooth high keeps the waveform
        set_ctrl(0, 0, 1, 0);
        observe(0, c0, 1, 4, 2, 1, 24, "R8 hold");
        // R8: both low forces high
        set_ctrl(0, 0, 0, 0);
        observe(0, 0, 0, 2, 5, 1, 20, "R8 idle high");

        // R7: smooth commit waits for the wrap, survives trigger clear
        commit(2, 0, 20, 5, 1, c0);
        observe(2, c0, 0, 20, 5, 1, 7, "R7 before");
        wr(8'h04, pre_img); wr(8'h18, 6); wr(8'h1C, 3);
        set_ctrl(2, 0, 1, 1);
        set_ctrl(2, 1, 1, 1);
        w = last_edge;
        set_ctrl(2, 0, 1, 1);
        p = 20;
        e = c0 + ((w + 2 - c0 + p - 1) / p) * p;
        begin
            int bad = 0; bit a1 = 0, e1 = 0;
            for (int k = 0; k < 60; k++) begin
                bit ex;
                @(negedge clk);
                ex = (cyc < e) ? exp_bit(cyc - c0, 0, 20, 5, 1)
                               : exp_bit(cyc - e, 0, 6, 3, 1);
                if (pwm_out[2] !== ex) begin
                    if (bad == 0) begin a1 = pwm_out[2]; e1 = ex; end
                    bad++;
                end
            end
            chk(bad == 0, "R7 smooth switch", 32'(a1), 32'(e1));
        end

        // R9: channel 5 commit leaves channel 0 running unchanged
        commit(0, 0, 5, 2, 1, c0);
        commit(5, 1, 3, 1, 0, c5);
        observe(0, c0, 0, 5, 2, 1, 30, "R9 ch0 kept");
        observe(5, c5, 1, 3, 1, 0, 30, "R9 ch5 own");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule